// File: doc/BRIEF.md
# Ethernet MAC control and status register file

This block is the software-visible register set of an Ethernet MAC. It sits on a simple single-beat 32-bit register bus. It holds the operating mode, the inter-packet gap, the frame length limits, two MII management registers, a 64-bit multicast hash, and a 48-bit station address that is split over two words. It also holds an interrupt source register and an interrupt mask. Every stored value is driven out continuously on configuration pins, so the transmit, receive and management logic can use it without going through the bus.

The transmit and receive paths raise interrupt causes with one-cycle pulses on `irq_set`. Each pulse sets the matching source bit, and the bit stays set until software writes a one to it. The interrupt line is registered. It is high when any source bit that has its mask bit set is high. An address window maps to a small descriptor RAM of 32-bit words. Bus reads are returned one cycle after the request together with a valid strobe. The bus has no back-pressure: every request is taken in the cycle it is presented. Unused addresses read as zero and cannot be written.

Register byte offsets:

| Offset | Register | Access |
|---|---|---|
| 0x00 | mode | read/write |
| 0x04 | interrupt source | write 1 to clear |
| 0x08 | interrupt mask | read/write |
| 0x0C | gap | read/write |
| 0x10 | length limits | read/write |
| 0x14 | MII control | read/write |
| 0x18 | MII write data | read/write |
| 0x1C | MII read data | read-only |
| 0x20 | MII status | read-only |
| 0x24 | station word 0 | read/write |
| 0x28 | station word 1 | read/write |
| 0x2C | hash low | read/write |
| 0x30 | hash high | read/write |
| 0x400 | descriptor window start | read/write |

Top module: `mac_csr_top`

## Requirements
- R1: After reset every stored register, every source bit, `irq_o`, `bus_rdata` and `bus_rvalid` are zero.
- R2: Mode (0x00), gap (0x0C), length limits (0x10), MII control (0x14), MII write data (0x18), hash low (0x2C) and hash high (0x30) store the full written word. Each reads back unchanged and appears on its configuration output. The mask (0x08) stores bits N_IRQ-1:0, and its upper bits read as zero.
- R3: A write to the source register (0x04) clears every source bit written as 1. Bits written as 0 keep their value. With no set pulse and no such write, the source bits hold.
- R4: A pulse on `irq_set[i]` sets source bit i at the next edge. This happens even when the same cycle carries a write that clears that bit.
- R5: `irq_o` is registered. It equals the OR over all i of (source[i] AND mask[i]) as those values stood one cycle earlier.
- R6: Station word 0 (0x24) holds byte 0 in bits 7:0, byte 1 in 15:8, byte 2 in 23:16 and byte 3 in 31:24. A write loads all four bytes, and a read returns them in the same positions.
- R7: Station word 1 (0x28) holds byte 4 in bits 7:0 and byte 5 in bits 15:8. A write loads only those two bytes, and bits 31:16 read as zero. `station_addr` is {byte5, …, byte0}.
- R8: A byte address A with BD_BASE ≤ A < BD_BASE + 4·BD_WORDS reads and writes descriptor word (A − BD_BASE)/4.
- R9: A read of any other address returns zero, and a write to one changes no register.
- R10: `bus_rvalid` rises exactly one cycle after a read request, with the data in `bus_rdata`. It stays low after writes and idle cycles.
- R11: MII read data (0x1C) and MII status (0x20) read the `mii_rdata_i` and `mii_status_i` inputs. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Request strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| irq_set | input | N_IRQ | Hardware set pulses for the source bits |
| mii_rdata_i | input | 32 | Data returned by the management engine |
| mii_status_i | input | 32 | Management engine status |
| cfg_mode | output | 32 | Mode register |
| cfg_gap | output | 32 | Gap register |
| cfg_len | output | 32 | Length limits register |
| cfg_mii_ctrl | output | 32 | MII control register |
| cfg_mii_wdata | output | 32 | MII write data register |
| cfg_hash | output | 64 | {hash high, hash low} |
| station_addr | output | 48 | Station address {byte5..byte0} |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench sweeps every source pattern against several clear patterns. A design that cleared on a written zero, or replaced the register with the written word, reads back the wrong value. A set pulse that arrives together with a clearing write checks set priority; a design where the clear wins drops a new cause. The mask sweep checks the gating and the one-cycle lag of the interrupt line, so an unregistered line shows up one cycle early. The bench also writes both station words and reads them back, which catches swapped bytes and any leak into the upper half of word 1. Finally, it probes addresses just outside the descriptor window and between registers; a loose decoder there returns data or corrupts a neighbour.

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;

  localparam logic [31:0] OFS_MODE    = 32'h00;
  localparam logic [31:0] OFS_SRC     = 32'h04;
  localparam logic [31:0] OFS_MASK    = 32'h08;
  localparam logic [31:0] OFS_GAP     = 32'h0C;
  localparam logic [31:0] OFS_LEN     = 32'h10;
  localparam logic [31:0] OFS_MCTRL   = 32'h14;
  localparam logic [31:0] OFS_MWDATA  = 32'h18;
  localparam logic [31:0] OFS_MRDATA  = 32'h1C;
  localparam logic [31:0] OFS_MSTAT   = 32'h20;
  localparam logic [31:0] OFS_STA0    = 32'h24;
  localparam logic [31:0] OFS_STA1    = 32'h28;
  localparam logic [31:0] OFS_HASHLO  = 32'h2C;
  localparam logic [31:0] OFS_HASHHI  = 32'h30;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_SRC,
    SEL_MASK,
    SEL_GAP,
    SEL_LEN,
    SEL_MCTRL,
    SEL_MWDATA,
    SEL_MRDATA,
    SEL_MSTAT,
    SEL_STA0,
    SEL_STA1,
    SEL_HASHLO,
    SEL_HASHHI,
    SEL_DESC
  } csr_sel_e;

endpackage

// File: rtl/mac_csr_decode.sv
module mac_csr_decode
  import mac_csr_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] BD_BASE  = 32'h400,
  parameter int          BD_WORDS = 16,
  localparam int         IDX_W    = $clog2(BD_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          sel,
  output logic [IDX_W-1:0]  desc_idx
);

  localparam logic [31:0] BD_END = BD_BASE + 32'(4 * BD_WORDS);

  logic [31:0] a32;
  logic [31:0] off;

  assign a32      = 32'(addr);
  assign off      = a32 - BD_BASE;
  assign desc_idx = off[IDX_W+1:2];

  always_comb begin
    sel = SEL_NONE;
    if (a32 >= BD_BASE && a32 < BD_END) begin
      sel = SEL_DESC;
    end else begin
      unique case (a32)
        OFS_MODE:   sel = SEL_MODE;
        OFS_SRC:    sel = SEL_SRC;
        OFS_MASK:   sel = SEL_MASK;
        OFS_GAP:    sel = SEL_GAP;
        OFS_LEN:    sel = SEL_LEN;
        OFS_MCTRL:  sel = SEL_MCTRL;
        OFS_MWDATA: sel = SEL_MWDATA;
        OFS_MRDATA: sel = SEL_MRDATA;
        OFS_MSTAT:  sel = SEL_MSTAT;
        OFS_STA0:   sel = SEL_STA0;
        OFS_STA1:   sel = SEL_STA1;
        OFS_HASHLO: sel = SEL_HASHLO;
        OFS_HASHHI: sel = SEL_HASHHI;
        default:    sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/mac_csr_irq.sv
module mac_csr_irq #(
  parameter int N_IRQ = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] set_i,
  input  logic             clr_we,
  input  logic [N_IRQ-1:0] clr_data,
  input  logic [N_IRQ-1:0] mask_i,
  output logic [N_IRQ-1:0] src_o,
  output logic             irq_o
);

  logic [N_IRQ-1:0] src_q;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        src_q[i] <= 1'b0;
      else if (set_i[i])
        src_q[i] <= 1'b1;
      else if (clr_we && clr_data[i])
        src_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(src_q & mask_i);
  end

  assign src_o = src_q;

endmodule

// File: rtl/mac_csr_descram.sv
module mac_csr_descram #(
  parameter int  WORDS = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/mac_csr_top.sv
module mac_csr_top
  import mac_csr_pkg::*;
#(
  parameter int          N_IRQ    = 7,
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] BD_BASE  = 32'h400,
  parameter int          BD_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [N_IRQ-1:0]  irq_set,
  input  logic [31:0]       mii_rdata_i,
  input  logic [31:0]       mii_status_i,
  output logic [31:0]       cfg_mode,
  output logic [31:0]       cfg_gap,
  output logic [31:0]       cfg_len,
  output logic [31:0]       cfg_mii_ctrl,
  output logic [31:0]       cfg_mii_wdata,
  output logic [63:0]       cfg_hash,
  output logic [47:0]       station_addr,
  output logic              irq_o
);

  localparam int IDX_W = $clog2(BD_WORDS);

  csr_sel_e         sel;
  logic [IDX_W-1:0] desc_idx;
  logic             wr, rd;
  logic [N_IRQ-1:0] src_q, mask_q;
  logic [31:0]      mode_q, gap_q, len_q, mctrl_q, mwdata_q, hlo_q, hhi_q;
  logic [7:0]       sta_q [6];
  logic [31:0]      desc_rd, rd_mux;

  assign wr = bus_sel &&  bus_we;
  assign rd = bus_sel && !bus_we;

  mac_csr_decode #(
    .ADDR_W(ADDR_W), .BD_BASE(BD_BASE), .BD_WORDS(BD_WORDS)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .desc_idx(desc_idx)
  );

  mac_csr_irq #(.N_IRQ(N_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(irq_set),
    .clr_we(wr && sel == SEL_SRC), .clr_data(bus_wdata[N_IRQ-1:0]),
    .mask_i(mask_q), .src_o(src_q), .irq_o(irq_o)
  );

  mac_csr_descram #(.WORDS(BD_WORDS)) u_desc (
    .clk(clk), .we(wr && sel == SEL_DESC), .idx(desc_idx),
    .wdata(bus_wdata), .rdata(desc_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      mask_q   <= '0;
      gap_q    <= '0;
      len_q    <= '0;
      mctrl_q  <= '0;
      mwdata_q <= '0;
      hlo_q    <= '0;
      hhi_q    <= '0;
      for (int b = 0; b < 6; b++) sta_q[b] <= '0;
    end else if (wr) begin
      case (sel)
        SEL_MODE:   mode_q   <= bus_wdata;
        SEL_MASK:   mask_q   <= bus_wdata[N_IRQ-1:0];
        SEL_GAP:    gap_q    <= bus_wdata;
        SEL_LEN:    len_q    <= bus_wdata;
        SEL_MCTRL:  mctrl_q  <= bus_wdata;
        SEL_MWDATA: mwdata_q <= bus_wdata;
        SEL_HASHLO: hlo_q    <= bus_wdata;
        SEL_HASHHI: hhi_q    <= bus_wdata;
        SEL_STA0: begin
          for (int b = 0; b < 4; b++) sta_q[b] <= bus_wdata[8*b +: 8];
        end
        SEL_STA1: begin
          sta_q[4] <= bus_wdata[7:0];
          sta_q[5] <= bus_wdata[15:8];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_MODE:   rd_mux = mode_q;
      SEL_SRC:    rd_mux = 32'(src_q);
      SEL_MASK:   rd_mux = 32'(mask_q);
      SEL_GAP:    rd_mux = gap_q;
      SEL_LEN:    rd_mux = len_q;
      SEL_MCTRL:  rd_mux = mctrl_q;
      SEL_MWDATA: rd_mux = mwdata_q;
      SEL_MRDATA: rd_mux = mii_rdata_i;
      SEL_MSTAT:  rd_mux = mii_status_i;
      SEL_STA0:   rd_mux = {sta_q[3], sta_q[2], sta_q[1], sta_q[0]};
      SEL_STA1:   rd_mux = {16'h0, sta_q[5], sta_q[4]};
      SEL_HASHLO: rd_mux = hlo_q;
      SEL_HASHHI: rd_mux = hhi_q;
      SEL_DESC:   rd_mux = desc_rd;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_mux : '0;
    end
  end

  assign cfg_mode      = mode_q;
  assign cfg_gap       = gap_q;
  assign cfg_len       = len_q;
  assign cfg_mii_ctrl  = mctrl_q;
  assign cfg_mii_wdata = mwdata_q;
  assign cfg_hash      = {hhi_q, hlo_q};
  assign station_addr  = {sta_q[5], sta_q[4], sta_q[3], sta_q[2], sta_q[1], sta_q[0]};

endmodule

// File: rtl/mac_csr_chk.sv
module mac_csr_chk
  import mac_csr_pkg::*;
#(
  parameter int          N_IRQ    = 7,
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] BD_BASE  = 32'h400,
  parameter int          BD_WORDS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic [N_IRQ-1:0]  irq_set,
  input logic [N_IRQ-1:0]  src,
  input logic [N_IRQ-1:0]  mask,
  input logic              irq_o
);

  logic [31:0] a32;
  logic        clr_wr, rd_req, mapped;

  assign a32    = 32'(bus_addr);
  assign clr_wr = bus_sel && bus_we && a32 == OFS_SRC;
  assign rd_req = bus_sel && !bus_we;
  assign mapped = (a32 >= BD_BASE && a32 < BD_BASE + 32'(4 * BD_WORDS)) ||
                  (a32 <= OFS_HASHHI && a32[1:0] == 2'b00);

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid); // R10
  AST_NO_RVALID_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid); // R10
  AST_CLEAR_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((src & $past(bus_wdata[N_IRQ-1:0]) & ~$past(irq_set)) == '0)); // R3
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set == '0 && !clr_wr) |=> src == $past(src)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set != '0) |=> ((src & $past(irq_set)) == $past(irq_set))); // R4
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past((src & mask) != '0)); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !mapped) |=> bus_rdata == 32'h0); // R9
  AST_STA1_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && a32 == OFS_STA1) |=> bus_rdata[31:16] == 16'h0); // R7

endmodule

bind mac_csr_top mac_csr_chk #(
  .N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .BD_BASE(BD_BASE), .BD_WORDS(BD_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .irq_set(irq_set), .src(src_q), .mask(mask_q),
  .irq_o(irq_o)
);

// File: tb/test_mac_csr_top.sv
module test_mac_csr_top;

  localparam int N_IRQ    = 7;
  localparam int ADDR_W   = 12;
  localparam int BD_BASE  = 'h400;
  localparam int BD_WORDS = 16;
  localparam logic [N_IRQ-1:0] ALL = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [N_IRQ-1:0]  irq_set = '0;
  logic [31:0]       mii_rdata_i = '0, mii_status_i = '0;
  logic [31:0]       cfg_mode, cfg_gap, cfg_len, cfg_mii_ctrl, cfg_mii_wdata;
  logic [63:0]       cfg_hash;
  logic [47:0]       station_addr;
  logic              irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mac_csr_top i_mac_csr_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_set(irq_set), .mii_rdata_i(mii_rdata_i),
    .mii_status_i(mii_status_i), .cfg_mode(cfg_mode), .cfg_gap(cfg_gap),
    .cfg_len(cfg_len), .cfg_mii_ctrl(cfg_mii_ctrl), .cfg_mii_wdata(cfg_mii_wdata),
    .cfg_hash(cfg_hash), .station_addr(station_addr), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    chk("R10 no rvalid after write", 64'(bus_rvalid), 64'd0);
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_sel = 1'b0;
    checks++;
    if (bus_rvalid !== 1'b1) begin
      errors++;
      $display("FAIL R10 rvalid: actual %b expected 1", bus_rvalid);
    end
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [N_IRQ-1:0] p);
    @(negedge clk);
    irq_set = p;
    @(negedge clk);
    irq_set = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int rw_ofs [8];
    logic [31:0] pats [6];
    rw_ofs = '{'h00, 'h0C, 'h10, 'h14, 'h18, 'h2C, 'h30, 'h08};
    pats   = '{32'hFFFFFFFF, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'h00000001,
               32'h80000000, 32'h00000000};

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq", 64'(irq_o), 0);
    chk("R1 rvalid", 64'(bus_rvalid), 0);
    chk("R1 rdata", 64'(bus_rdata), 0);
    rst_n = 1'b1;
    chk("R1 cfg", {cfg_mode ^ cfg_gap ^ cfg_len, cfg_mii_ctrl | cfg_mii_wdata}, 0);
    chk("R1 hash", cfg_hash, 0);
    chk("R1 station", 64'(station_addr), 0);
    for (int k = 0; k < 8; k++) begin
      rd(rw_ofs[k], d);
      chk("R1 reg", 64'(d), 0);
    end
    rd('h04, d);
    chk("R1 src", 64'(d), 0);

    // R2: storage sweep
    foreach (pats[p]) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] v;
        v = pats[p] ^ (32'(k) << 4);
        wr(rw_ofs[k], v);
        rd(rw_ofs[k], d);
        chk("R2 readback", 64'(d), 64'(k == 7 ? (v & 32'(ALL)) : v));
      end
      chk("R2 cfg_mode", 64'(cfg_mode), 64'(pats[p]));
      chk("R2 cfg_gap", 64'(cfg_gap), 64'(pats[p] ^ 32'h10));
      chk("R2 cfg_len", 64'(cfg_len), 64'(pats[p] ^ 32'h20));
      chk("R2 cfg_mii", {cfg_mii_ctrl, cfg_mii_wdata}, {pats[p] ^ 32'h30, pats[p] ^ 32'h40});
      chk("R2 cfg_hash", cfg_hash, {pats[p] ^ 32'h60, pats[p] ^ 32'h50});
    end

    // R3: W1C sweep over every source pattern
    wr('h08, 32'h0);
    for (int p = 0; p < (1 << N_IRQ); p++) begin
      logic [N_IRQ-1:0] cl [4];
      cl = '{'0, ALL, N_IRQ'(p), N_IRQ'(p * 5 + 3)};
      for (int c = 0; c < 4; c++) begin
        wr('h04, 32'(ALL));
        pulse(N_IRQ'(p));
        wr('h04, 32'(cl[c]));
        rd('h04, d);
        chk("R3 w1c", 64'(d), 64'(N_IRQ'(p) & ~cl[c]));
      end
    end

    // R4: set beats simultaneous clear
    for (int b = 0; b < N_IRQ; b++) begin
      wr('h04, 32'(ALL));
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'('h04); bus_wdata = 32'(ALL);
      irq_set = N_IRQ'(1 << b);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; irq_set = '0;
      rd('h04, d);
      chk("R4 set wins", 64'(d), 64'(1 << b));
    end

    // R5: mask gating and one-cycle lag
    for (int m = 0; m < (1 << N_IRQ); m += 9) begin
      for (int b = 0; b < N_IRQ; b++) begin
        wr('h04, 32'(ALL));
        wr('h08, 32'(m));
        @(negedge clk);
        chk("R5 idle", 64'(irq_o), 0);
        pulse(N_IRQ'(1 << b));
        chk("R5 lag", 64'(irq_o), 0);
        @(negedge clk);
        chk("R5 irq", 64'(irq_o), 64'(((m >> b) & 1) != 0));
      end
    end
    wr('h08, 32'(ALL));
    wr('h04, 32'(ALL));
    @(negedge clk);
    chk("R5 cleared", 64'(irq_o), 0);

    // R6 / R7: station address packing
    wr('h24, 32'h11223344);
    wr('h28, 32'hCCDDAABB);
    rd('h24, d);
    chk("R6 word0", 64'(d), 64'h11223344);
    rd('h28, d);
    chk("R7 word1", 64'(d), 64'h0000AABB);
    chk("R7 station", 64'(station_addr), 64'hAABB11223344);
    wr('h24, 32'h01020304);
    chk("R6 station", 64'(station_addr), 64'hAABB01020304);

    // R8: descriptor window fill and readback
    for (int w = 0; w < BD_WORDS; w++) wr(BD_BASE + 4 * w, 32'hD0000000 + 32'(w * 17));
    for (int w = 0; w < BD_WORDS; w++) begin
      rd(BD_BASE + 4 * w + (w % 4), d);
      chk("R8 desc", 64'(d), 64'(32'hD0000000 + 32'(w * 17)));
    end

    // R9: unmapped addresses
    begin
      int um [6];
      um = '{'h34, 'h3FC, BD_BASE + 4 * BD_WORDS, 'hFFC, 'h02, 'h100};
      for (int u = 0; u < 6; u++) begin
        wr(um[u], 32'hFFFFFFFF);
        rd(um[u], d);
        chk("R9 read zero", 64'(d), 0);
      end
      rd('h00, d);
      chk("R9 mode intact", 64'(d), 64'(32'h00000000));
      rd('h24, d);
      chk("R9 sta intact", 64'(d), 64'h01020304);
      rd(BD_BASE, d);
      chk("R9 desc0 intact", 64'(d), 64'hD0000000);
      rd(BD_BASE + 4 * (BD_WORDS - 1), d);
      chk("R9 desc last intact", 64'(d), 64'(32'hD0000000 + 32'((BD_WORDS - 1) * 17)));
    end

    // R11: read-only MII inputs
    mii_rdata_i = 32'h1357_9BDF;
    mii_status_i = 32'h0000_0005;
    wr('h1C, 32'h0);
    wr('h20, 32'hFFFF);
    rd('h1C, d);
    chk("R11 rdata", 64'(d), 64'h13579BDF);
    rd('h20, d);
    chk("R11 status", 64'(d), 64'h5);

    // R10: idle cycle gives no rvalid
    @(negedge clk);
    chk("R10 idle", 64'(bus_rvalid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule